// File: doc/BRIEF.md
# Capability Rights-Reduction Unit

This unit carries out the four operations that narrow or freeze a capability held in uncompressed form: shrinking its bounds, clearing permission bits, sealing it with an object type, and unsealing it again. A capability here is a tag bit, a sealed flag, an object type, a permission word, an inclusive base, an exclusive top and a cursor. The caller presents a source capability, an operand and an opcode together with a valid strobe. One cycle later the unit returns the result capability with a result strobe.

The unit never traps. A request that would widen rights, touch a sealed capability, or lack proper authority is still carried out on every field. The only difference is that the result leaves with its tag cleared, and a cleared tag makes it unusable as a capability. An untagged source can therefore never become tagged. Bounds and object types are exact, because compressed-bounds rounding belongs to another stage.

Top module: `cap_modifier`

## Requirements
- R1: The result fields and `res_valid` are registered one clock after `op_valid` is sampled high. `res_valid` is low in any cycle that follows a cycle without `op_valid`, and in that cycle the result fields keep their last values. Reset clears every output to zero.
- R2: Opcode 0 (set bounds) sets the result base to the source cursor and the result top to cursor plus length, computed one bit wider than an address. The tag is kept when the source is tagged and unsealed, the cursor is at least the source base, and the new top does not exceed the source top.
- R3: A set-bounds request that would reach below the source base or above the source top gives an untagged result. Its base and top are still the computed values.
- R4: Opcode 1 (and-permissions) makes the result permissions the bitwise AND of the source permissions and the mask. The tag is kept for a tagged, unsealed source.
- R5: A sealed source given to opcode 0 or 1 gives an untagged result. The sealed flag and object type pass through unchanged, and the other fields follow R2 or R4.
- R6: Opcode 2 (seal) gives a sealed result whose object type is the low 16 bits of the authority cursor. The tag is kept when the source is tagged and unsealed and the authority is usable with permission bit 4 set. An authority is usable when it is tagged and unsealed, its cursor lies in [base, top), and its cursor is below 2^16.
- R7: A seal request whose authority lacks bit 4, is untagged, is sealed, has its cursor outside its bounds or at or above 2^16, or whose source is already sealed, gives an untagged result.
- R8: Opcode 3 (unseal) gives an unsealed result with object type zero. The tag is kept when the source is tagged and sealed, and the authority is usable with permission bit 5 set and a cursor equal to the source object type.
- R9: An unseal request whose source is unsealed, or whose authority lacks bit 5, is unusable, or has a cursor that differs from the source object type, gives an untagged result.
- R10: An untagged source always gives an untagged result, and the computation of the other fields is unchanged.
- R11: The result cursor always equals the source cursor, and the fields an operation does not change are copied from the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request strobe |
| op_code | input | 2 | 0 set bounds, 1 and-perms, 2 seal, 3 unseal |
| src_tag | input | 1 | Source validity tag |
| src_sealed | input | 1 | Source sealed flag |
| src_otype | input | OTYPE_W | Source object type |
| src_perms | input | PERM_W | Source permissions |
| src_base | input | ADDR_W | Source lower bound (inclusive) |
| src_top | input | ADDR_W+1 | Source upper bound (exclusive) |
| src_cursor | input | ADDR_W | Source address |
| opnd_len | input | ADDR_W | Requested length for set bounds |
| opnd_mask | input | PERM_W | Permission mask for and-perms |
| auth_tag | input | 1 | Authority tag |
| auth_sealed | input | 1 | Authority sealed flag |
| auth_perms | input | PERM_W | Authority permissions |
| auth_base | input | ADDR_W | Authority lower bound |
| auth_top | input | ADDR_W+1 | Authority upper bound |
| auth_cursor | input | ADDR_W | Authority cursor, the object type |
| res_valid | output | 1 | Result strobe |
| res_tag | output | 1 | Result tag |
| res_sealed | output | 1 | Result sealed flag |
| res_otype | output | OTYPE_W | Result object type |
| res_perms | output | PERM_W | Result permissions |
| res_base | output | ADDR_W | Result base |
| res_top | output | ADDR_W+1 | Result top |
| res_cursor | output | ADDR_W | Result cursor |

## Verification
The assertions assume that inputs are stable and known when `op_valid` is high, and that `op_code` only takes the four defined values, so each property can relate the previous cycle's request to the present result. The bench drives every input at the falling edge and draws opcodes only from that set. Bounds and cursors come from narrow windows placed next to base and top, including a top of 2^64, so that both accepted and widening requests occur often. Authority cursors are steered to match or miss the object type and to cross the 2^16 limit.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int ADDR_W_DEF     = 64;
    localparam int PERM_W_DEF     = 16;
    localparam int OTYPE_W_DEF    = 16;
    localparam int SEAL_BIT_DEF   = 4;
    localparam int UNSEAL_BIT_DEF = 5;

    typedef enum logic [1:0] {
        OP_BOUNDS  = 2'd0,
        OP_ANDPERM = 2'd1,
        OP_SEAL    = 2'd2,
        OP_UNSEAL  = 2'd3
    } cap_op_e;
endpackage

// File: rtl/cap_bounds_unit.sv
module cap_bounds_unit #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W:0]   top_i,
    input  logic [ADDR_W-1:0] cursor_i,
    input  logic [ADDR_W-1:0] len_i,
    output logic [ADDR_W:0]   new_top_o,
    output logic              inside_o
);
    // the wide sum keeps a region ending at 2^ADDR_W representable
    always_comb begin
        new_top_o = {1'b0, cursor_i} + {1'b0, len_i};
        inside_o  = (cursor_i >= base_i) && (new_top_o <= top_i);
    end
endmodule

// File: rtl/cap_auth_unit.sv
module cap_auth_unit #(
    parameter int ADDR_W     = 64,
    parameter int PERM_W     = 16,
    parameter int OTYPE_W    = 16,
    parameter int SEAL_BIT   = 4,
    parameter int UNSEAL_BIT = 5
) (
    input  logic               tag_i,
    input  logic               sealed_i,
    input  logic [PERM_W-1:0]  perms_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [ADDR_W:0]    top_i,
    input  logic [ADDR_W-1:0]  cursor_i,
    input  logic [OTYPE_W-1:0] target_otype_i,
    output logic [OTYPE_W-1:0] otype_o,
    output logic               seal_ok_o,
    output logic               unseal_ok_o
);
    logic usable;
    logic fits;

    always_comb begin
        fits        = (cursor_i >> OTYPE_W) == '0;
        usable      = tag_i && !sealed_i && fits
                      && (cursor_i >= base_i) && ({1'b0, cursor_i} < top_i);
        otype_o     = cursor_i[OTYPE_W-1:0];
        seal_ok_o   = usable && perms_i[SEAL_BIT];
        unseal_ok_o = usable && perms_i[UNSEAL_BIT] && (otype_o == target_otype_i);
    end
endmodule

// File: rtl/cap_modifier.sv
module cap_modifier
    import cap_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int PERM_W     = PERM_W_DEF,
    parameter int OTYPE_W    = OTYPE_W_DEF,
    parameter int SEAL_BIT   = SEAL_BIT_DEF,
    parameter int UNSEAL_BIT = UNSEAL_BIT_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [1:0]         op_code,
    input  logic               src_tag,
    input  logic               src_sealed,
    input  logic [OTYPE_W-1:0] src_otype,
    input  logic [PERM_W-1:0]  src_perms,
    input  logic [ADDR_W-1:0]  src_base,
    input  logic [ADDR_W:0]    src_top,
    input  logic [ADDR_W-1:0]  src_cursor,
    input  logic [ADDR_W-1:0]  opnd_len,
    input  logic [PERM_W-1:0]  opnd_mask,
    input  logic               auth_tag,
    input  logic               auth_sealed,
    input  logic [PERM_W-1:0]  auth_perms,
    input  logic [ADDR_W-1:0]  auth_base,
    input  logic [ADDR_W:0]    auth_top,
    input  logic [ADDR_W-1:0]  auth_cursor,
    output logic               res_valid,
    output logic               res_tag,
    output logic               res_sealed,
    output logic [OTYPE_W-1:0] res_otype,
    output logic [PERM_W-1:0]  res_perms,
    output logic [ADDR_W-1:0]  res_base,
    output logic [ADDR_W:0]    res_top,
    output logic [ADDR_W-1:0]  res_cursor
);
    typedef struct packed {
        logic               valid;
        logic               tag;
        logic               sealed;
        logic [OTYPE_W-1:0] otype;
        logic [PERM_W-1:0]  perms;
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W:0]    top;
        logic [ADDR_W-1:0]  cursor;
    } res_t;

    res_t res_d, res_q;

    logic [ADDR_W:0]    bnd_top;
    logic               bnd_inside;
    logic [OTYPE_W-1:0] auth_otype;
    logic               seal_ok;
    logic               unseal_ok;
    cap_op_e            op;

    cap_bounds_unit #(.ADDR_W(ADDR_W)) u_bounds (
        .base_i    (src_base),
        .top_i     (src_top),
        .cursor_i  (src_cursor),
        .len_i     (opnd_len),
        .new_top_o (bnd_top),
        .inside_o  (bnd_inside)
    );

    cap_auth_unit #(
        .ADDR_W(ADDR_W), .PERM_W(PERM_W), .OTYPE_W(OTYPE_W),
        .SEAL_BIT(SEAL_BIT), .UNSEAL_BIT(UNSEAL_BIT)
    ) u_auth (
        .tag_i          (auth_tag),
        .sealed_i       (auth_sealed),
        .perms_i        (auth_perms),
        .base_i         (auth_base),
        .top_i          (auth_top),
        .cursor_i       (auth_cursor),
        .target_otype_i (src_otype),
        .otype_o        (auth_otype),
        .seal_ok_o      (seal_ok),
        .unseal_ok_o    (unseal_ok)
    );

    always_comb begin
        op          = cap_op_e'(op_code);
        res_d       = res_q;
        res_d.valid = op_valid;
        if (op_valid) begin
            // fields untouched by the operation are copied from the source
            res_d.cursor = src_cursor;
            res_d.base   = src_base;
            res_d.top    = src_top;
            res_d.perms  = src_perms;
            res_d.otype  = src_otype;
            res_d.sealed = src_sealed;
            unique case (op)
                OP_BOUNDS: begin
                    res_d.base = src_cursor;
                    res_d.top  = bnd_top;
                    res_d.tag  = src_tag && !src_sealed && bnd_inside;
                end
                OP_ANDPERM: begin
                    res_d.perms = src_perms & opnd_mask;
                    res_d.tag   = src_tag && !src_sealed;
                end
                OP_SEAL: begin
                    res_d.sealed = 1'b1;
                    res_d.otype  = auth_otype;
                    res_d.tag    = src_tag && !src_sealed && seal_ok;
                end
                OP_UNSEAL: begin
                    res_d.sealed = 1'b0;
                    res_d.otype  = '0;
                    res_d.tag    = src_tag && src_sealed && unseal_ok;
                end
                default: res_d.tag = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid  = res_q.valid;
    assign res_tag    = res_q.tag;
    assign res_sealed = res_q.sealed;
    assign res_otype  = res_q.otype;
    assign res_perms  = res_q.perms;
    assign res_base   = res_q.base;
    assign res_top    = res_q.top;
    assign res_cursor = res_q.cursor;
endmodule

// File: rtl/cap_modifier_chk.sv
module cap_modifier_chk #(
    parameter int ADDR_W     = 64,
    parameter int PERM_W     = 16,
    parameter int OTYPE_W    = 16,
    parameter int SEAL_BIT   = 4,
    parameter int UNSEAL_BIT = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid,
    input logic [1:0]         op_code,
    input logic               src_tag,
    input logic               src_sealed,
    input logic [OTYPE_W-1:0] src_otype,
    input logic [PERM_W-1:0]  src_perms,
    input logic [ADDR_W-1:0]  src_base,
    input logic [ADDR_W:0]    src_top,
    input logic [ADDR_W-1:0]  src_cursor,
    input logic [PERM_W-1:0]  opnd_mask,
    input logic [PERM_W-1:0]  auth_perms,
    input logic [ADDR_W-1:0]  auth_cursor,
    input logic               res_valid,
    input logic               res_tag,
    input logic [PERM_W-1:0]  res_perms,
    input logic [ADDR_W-1:0]  res_base,
    input logic [ADDR_W:0]    res_top,
    input logic [ADDR_W-1:0]  res_cursor
);
    // R1
    strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    // R1
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);
    // R10
    no_tag_forge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !src_tag) |=> !res_tag);
    // R3
    bounds_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd0) |=> (!res_tag
            || (res_base >= $past(src_base) && res_top <= $past(src_top))));
    // R4
    perms_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd1) |=> ((res_perms & ~$past(src_perms)) == '0
            && (res_perms & ~$past(opnd_mask)) == '0));
    // R5
    sealed_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_code[1] && src_sealed) |=> !res_tag);
    // R7
    seal_needs_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd2 && !auth_perms[SEAL_BIT]) |=> !res_tag);
    // R9
    unseal_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd3
            && (auth_cursor != {{(ADDR_W-OTYPE_W){1'b0}}, src_otype}
                || !auth_perms[UNSEAL_BIT])) |=> !res_tag);
    // R11
    cursor_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_cursor == $past(src_cursor));
endmodule

bind cap_modifier cap_modifier_chk #(
    .ADDR_W(ADDR_W), .PERM_W(PERM_W), .OTYPE_W(OTYPE_W),
    .SEAL_BIT(SEAL_BIT), .UNSEAL_BIT(UNSEAL_BIT)
) u_chk (.*);

// File: tb/cap_modifier_bench.sv
module cap_modifier_bench;
    localparam int AW = 64;
    localparam int PW = 16;
    localparam int OW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          op_valid = 0;
    logic [1:0]    op_code = 0;
    logic          src_tag = 0, src_sealed = 0;
    logic [OW-1:0] src_otype = 0;
    logic [PW-1:0] src_perms = 0;
    logic [AW-1:0] src_base = 0;
    logic [AW:0]   src_top = 0;
    logic [AW-1:0] src_cursor = 0, opnd_len = 0;
    logic [PW-1:0] opnd_mask = 0;
    logic          auth_tag = 0, auth_sealed = 0;
    logic [PW-1:0] auth_perms = 0;
    logic [AW-1:0] auth_base = 0;
    logic [AW:0]   auth_top = 0;
    logic [AW-1:0] auth_cursor = 0;

    logic          res_valid, res_tag, res_sealed;
    logic [OW-1:0] res_otype;
    logic [PW-1:0] res_perms;
    logic [AW-1:0] res_base;
    logic [AW:0]   res_top;
    logic [AW-1:0] res_cursor;

    cap_modifier u_cap_modifier (.*);

    int tests = 0;
    int fails = 0;

    // reference state: what the outputs must show after the next edge
    logic          m_valid = 0, m_tag = 0, m_sealed = 0;
    logic [OW-1:0] m_otype = 0;
    logic [PW-1:0] m_perms = 0;
    logic [AW-1:0] m_base = 0, m_cursor = 0;
    logic [AW:0]   m_top = 0;
    string         m_req = "R1";

    task automatic check(input string req, input string what,
                         input logic [AW:0] act, input logic [AW:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R1", "valid", 65'(res_valid), 65'(m_valid));
        check(m_req, "tag", 65'(res_tag), 65'(m_tag));
        check(m_req, "sealed", 65'(res_sealed), 65'(m_sealed));
        check(m_req, "otype", 65'(res_otype), 65'(m_otype));
        check(m_req, "perms", 65'(res_perms), 65'(m_perms));
        check(m_req, "base", 65'(res_base), 65'(m_base));
        check(m_req, "top", res_top, m_top);
        check("R11", "cursor", 65'(res_cursor), 65'(m_cursor));
    endtask

    // behavioural model of one request, written from the requirements
    task automatic model_step();
        bit auth_good;
        m_valid = op_valid;
        if (!op_valid) begin
            m_req = "R1";
            return;
        end
        m_cursor = src_cursor; m_base = src_base; m_top = src_top;
        m_perms = src_perms; m_otype = src_otype; m_sealed = src_sealed;
        auth_good = auth_tag && !auth_sealed && auth_cursor < 64'h10000
                    && auth_cursor >= auth_base && {1'b0, auth_cursor} < auth_top;
        case (op_code)
            2'd0: begin
                m_base = src_cursor;
                m_top  = 65'(src_cursor) + 65'(opnd_len);
                if (!src_tag) begin m_tag = 0; m_req = "R10"; end
                else if (src_sealed) begin m_tag = 0; m_req = "R5"; end
                else if (src_cursor < src_base || m_top > src_top) begin m_tag = 0; m_req = "R3"; end
                else begin m_tag = 1; m_req = "R2"; end
            end
            2'd1: begin
                m_perms = src_perms & opnd_mask;
                if (!src_tag) begin m_tag = 0; m_req = "R10"; end
                else if (src_sealed) begin m_tag = 0; m_req = "R5"; end
                else begin m_tag = 1; m_req = "R4"; end
            end
            2'd2: begin
                m_sealed = 1;
                m_otype  = auth_cursor[OW-1:0];
                m_tag    = src_tag && !src_sealed && auth_good && auth_perms[4];
                m_req    = !src_tag ? "R10" : (m_tag ? "R6" : "R7");
            end
            default: begin
                m_sealed = 0;
                m_otype  = 0;
                m_tag    = src_tag && src_sealed && auth_good && auth_perms[5]
                           && auth_cursor == 64'(src_otype);
                m_req    = !src_tag ? "R10" : (m_tag ? "R8" : "R9");
            end
        endcase
    endtask

    task automatic randomize_inputs();
        logic [AW-1:0] b;
        int unsigned sel = $urandom_range(0, 9);
        b = (sel < 2) ? (64'hFFFF_FFFF_FFFF_FF00 + 64'($urandom_range(0, 64)))
                      : 64'($urandom_range(0, 1000));
        op_valid   = ($urandom_range(0, 5) != 0);
        op_code    = 2'($urandom_range(0, 3));
        src_tag    = ($urandom_range(0, 7) != 0);
        src_sealed = (op_code == 2'd3) ? ($urandom_range(0, 5) != 0)
                                       : ($urandom_range(0, 5) == 0);
        src_otype  = 16'($urandom_range(0, 20));
        src_perms  = 16'($urandom);
        src_base   = b;
        src_top    = (sel == 0) ? 65'h1_0000_0000_0000_0000
                                : 65'(b) + 65'($urandom_range(0, 200));
        src_cursor = b + 64'($urandom_range(0, 120)) - 64'($urandom_range(0, 8));
        opnd_len   = 64'($urandom_range(0, 160));
        opnd_mask  = 16'($urandom);
        auth_tag    = ($urandom_range(0, 7) != 0);
        auth_sealed = ($urandom_range(0, 7) == 0);
        auth_perms  = 16'($urandom);
        auth_base   = 64'($urandom_range(0, 6));
        auth_top    = 65'($urandom_range(10, 30));
        case ($urandom_range(0, 3))
            0:       auth_cursor = 64'(src_otype);
            1:       auth_cursor = 64'h10000 + 64'($urandom_range(0, 3));
            default: auth_cursor = 64'($urandom_range(0, 40));
        endcase
        if (auth_cursor >= 64'h10000) begin
            auth_base = 64'h0;
            auth_top  = 65'h2_0000;
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic clean_src(input logic [1:0] code);
        op_valid = 1; op_code = code;
        src_tag = 1; src_sealed = 0; src_otype = 16'h0;
        src_perms = 16'hFFFF; src_base = 64'h1000; src_top = 65'h1100;
        src_cursor = 64'h1010; opnd_len = 64'h20; opnd_mask = 16'h00F0;
        auth_tag = 1; auth_sealed = 0; auth_perms = 16'h0030;
        auth_base = 64'h5; auth_top = 65'h20; auth_cursor = 64'h9;
    endtask

    logic done = 0;
    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++; tests++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_all();                         // R1 reset state
        rst_n = 1;
        @(negedge clk);

        // R2 in-range bounds; then exact fit to top
        clean_src(2'd0); model_step(); step();
        src_cursor = 64'h1000; opnd_len = 64'h100; model_step(); step();
        // R3 one past top, and below base
        opnd_len = 64'h101; model_step(); step();
        src_cursor = 64'hFFF; opnd_len = 64'h1; model_step(); step();
        // R2 region ending exactly at 2^64
        src_base = 64'hFFFF_FFFF_FFFF_FFF0; src_top = 65'h1_0000_0000_0000_0000;
        src_cursor = 64'hFFFF_FFFF_FFFF_FFF8; opnd_len = 64'h8; model_step(); step();
        // R4 and-perms
        clean_src(2'd1); model_step(); step();
        // R5 sealed source to bounds and perms
        clean_src(2'd1); src_sealed = 1; src_otype = 16'h7; model_step(); step();
        clean_src(2'd0); src_sealed = 1; src_otype = 16'h7; model_step(); step();
        // R6 seal, R7 missing perm and cursor out of auth bounds
        clean_src(2'd2); model_step(); step();
        auth_perms = 16'h0020; model_step(); step();
        clean_src(2'd2); auth_cursor = 64'h20; model_step(); step();
        // R8 unseal matching, R9 mismatching
        clean_src(2'd3); src_sealed = 1; src_otype = 16'h9; model_step(); step();
        src_otype = 16'hA; model_step(); step();
        // R10 untagged source
        clean_src(2'd1); src_tag = 0; model_step(); step();
        // R1 idle cycle holds the fields
        op_valid = 0; model_step(); step();

        for (int i = 0; i < 3000; i++) begin
            randomize_inputs();
            model_step();
            step();
        end
        op_valid = 0; model_step(); step();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule